// File: doc/BRIEF.md
# Burst-Packing DMA FIFO Engine

This engine moves a programmed number of bytes between a byte-wide peripheral DMA channel and a 32-bit local bus master port. Traffic toward memory gathers bytes from the peripheral into a 32-byte burst buffer. Traffic toward the peripheral fills that buffer from memory. Bus ownership is requested only when a whole burst is ready to write, or when the buffer must be refilled. Each burst is at most eight word cycles. Bytes are repacked between the 8-bit channel and the 32-bit bus in big-endian lane order. An 8-byte staging FIFO sits between the burst buffer and the byte channel, so the peripheral keeps moving while the bus is being won.

Software selects the direction through a one-bit register and starts a transfer with a start pulse, a start address and a byte count. The last chunk may be smaller than a burst. It is moved in as few word cycles as it needs, and only its valid byte lanes are enabled. When every byte has been moved, a done level is set and a single-cycle interrupt pulse is raised.

Top module: `dma_burst_engine`

## Requirements
- R1: The direction bit resets to 0. A write while the engine is idle sets it, and it reads back on `cfg_dir_rd`. A write while a transfer is active is ignored. Value 1 means peripheral to memory; value 0 means memory to peripheral.
- R2: Peripheral to memory: `bus_req` rises only once 32 bytes are buffered, or once the buffer holds every byte still owed to memory. A full burst is 8 word cycles, and the number of bursts is the byte count divided by 32, rounded up.
- R3: Packing is big-endian. The earliest byte of each word goes to bits 31:24 and to the lowest byte address. `bus_be[3]` enables bits 31:24 and `bus_be[0]` enables bits 7:0.
- R4: Memory to peripheral: the engine reads up to 32 bytes in one burst, then presents them on `pout_data` in ascending address order. It does not request the bus again until the buffer is drained. No byte is offered on this port while the direction bit is 1.
- R5: Every byte offered on `pout_data` carries `pout_par`, chosen so that the nine bits hold an odd number of ones.
- R6: Once raised, `bus_req` stays high until `bus_gnt`. Word cycles (`bus_cyc`) start only after a sampled grant. `bus_req` falls in the cycle after the final word cycle of a burst.
- R7: The first word cycle uses the start address with bits 1:0 cleared. Each later word cycle of the transfer adds 4.
- R8: A final chunk of N<32 bytes takes ceil(N/4) word cycles. On writes, lanes past the last valid byte are disabled, so memory beyond the transfer is left unchanged.
- R9: When all bytes are moved, `xfer_irq` pulses for exactly one cycle and `xfer_done` goes high until the next accepted start. A count of 0 finishes with no bus request at all.
- R10: A start pulse while a transfer is active is ignored.
- R11: While the grant is withheld, the peripheral can deliver 8 bytes beyond a full burst buffer (40 in total) before `pin_ready` drops.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_dir_we | input | 1 | Direction register write strobe |
| cfg_dir_wd | input | 1 | Direction value to write |
| cfg_dir_rd | output | 1 | Direction register read-back |
| xfer_start | input | 1 | Start pulse (honoured only when idle) |
| xfer_addr | input | ADDR_W | Memory start address |
| xfer_count | input | CNT_W | Bytes to move |
| xfer_done | output | 1 | Set when the transfer completes, cleared by the next start |
| xfer_irq | output | 1 | One-cycle completion pulse |
| pin_valid | input | 1 | Peripheral byte available (toward memory) |
| pin_data | input | 8 | Peripheral byte |
| pin_ready | output | 1 | Engine accepts a peripheral byte |
| pout_valid | output | 1 | Byte offered to the peripheral |
| pout_data | output | 8 | Byte to the peripheral |
| pout_par | output | 1 | Odd parity of `pout_data` |
| pout_ready | input | 1 | Peripheral takes the byte |
| bus_req | output | 1 | Local bus ownership request |
| bus_gnt | input | 1 | Local bus grant |
| bus_cyc | output | 1 | Word cycle active |
| bus_we | output | 1 | 1 = write to memory, 0 = read |
| bus_addr | output | ADDR_W | Word address |
| bus_be | output | 4 | Byte lane enables |
| bus_wdata | output | 32 | Write data |
| bus_rdata | input | 32 | Read data, valid in the word cycle |

## Verification
A wrong fill or drain count inside the engine shows at the ports within one burst. The bus is requested too early or too late, a burst has the wrong number of word cycles, or a byte after the end of the transfer changes in memory. A lane-order fault scrambles every word written or read, so the first burst already shows it in memory contents or in the byte stream to the peripheral. A stuck request or a missing release shows as ownership held past the eighth word cycle. A count that never reaches zero leaves the done flag low, and the run then hits its timeout.

// File: rtl/dma_fifo_pkg.sv
package dma_fifo_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_FILL,
        ST_REQ,
        ST_BURST,
        ST_FINISH
    } eng_state_e;

    typedef struct packed {
        logic        cyc;
        logic        we;
        logic [3:0]  be;
        logic [31:0] data;
    } word_cyc_t;

    // odd parity: data plus parity bit carry an odd number of ones
    function automatic logic odd_par(input logic [7:0] b);
        return ~^b;
    endfunction

    // lane enables for the word starting at byte offset 'first' of a
    // buffer holding 'valid' bytes; lane 3 carries the earliest byte
    function automatic logic [3:0] lane_en(input int unsigned first,
                                           input int unsigned valid);
        logic [3:0] be;
        for (int j = 0; j < 4; j++) begin
            be[3-j] = (first + j) < valid;
        end
        return be;
    endfunction

endpackage

// File: rtl/dma_stage_fifo.sv
module dma_stage_fifo #(
    parameter int WIDTH = 8,
    parameter int DEPTH = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             push,
    input  logic [WIDTH-1:0] din,
    input  logic             pop,
    output logic [WIDTH-1:0] dout,
    output logic             full,
    output logic             empty
);
    localparam int AW = $clog2(DEPTH);

    logic [WIDTH-1:0] store [DEPTH];
    logic [AW-1:0]    wp_q, rp_q;
    logic [AW:0]      cnt_q;
    logic             do_push, do_pop;

    assign full    = cnt_q == (AW+1)'(DEPTH);
    assign empty   = cnt_q == '0;
    assign do_push = push && !full;
    assign do_pop  = pop && !empty;
    assign dout    = store[rp_q];

    always_ff @(posedge clk) begin
        if (rst) begin
            wp_q  <= '0;
            rp_q  <= '0;
            cnt_q <= '0;
        end else begin
            if (do_push) begin
                store[wp_q] <= din;
                wp_q        <= wp_q + 1'b1;
            end
            if (do_pop) rp_q <= rp_q + 1'b1;
            cnt_q <= cnt_q + (AW+1)'(do_push) - (AW+1)'(do_pop);
        end
    end
endmodule

// File: rtl/dma_burst_buf.sv
module dma_burst_buf #(
    parameter int BYTES = 32
) (
    input  logic                       clk,
    input  logic                       byte_we,
    input  logic [$clog2(BYTES)-1:0]   byte_idx,
    input  logic [7:0]                 byte_wd,
    input  logic [$clog2(BYTES)-1:0]   byte_rd_idx,
    output logic [7:0]                 byte_rd,
    input  logic                       word_we,
    input  logic [$clog2(BYTES/4)-1:0] word_idx,
    input  logic [31:0]                word_wd,
    output logic [31:0]                word_rd
);
    logic [7:0] cells [BYTES];

    assign byte_rd = cells[byte_rd_idx];

    // big-endian lanes: byte 4k sits in bits 31:24 of word k
    for (genvar g = 0; g < 4; g++) begin : g_lane
        assign word_rd[31-8*g -: 8] = cells[{word_idx, 2'(g)}];
    end

    always_ff @(posedge clk) begin
        if (byte_we) cells[byte_idx] <= byte_wd;
        if (word_we) begin
            for (int g = 0; g < 4; g++) begin
                cells[{word_idx, 2'(g)}] <= word_wd[31-8*g -: 8];
            end
        end
    end
endmodule

// File: rtl/dma_burst_engine.sv
module dma_burst_engine
    import dma_fifo_pkg::*;
#(
    parameter int ADDR_W      = 32,
    parameter int CNT_W       = 16,
    parameter int BURST_BYTES = 32,
    parameter int STAGE_DEPTH = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_dir_we,
    input  logic              cfg_dir_wd,
    output logic              cfg_dir_rd,
    input  logic              xfer_start,
    input  logic [ADDR_W-1:0] xfer_addr,
    input  logic [CNT_W-1:0]  xfer_count,
    output logic              xfer_done,
    output logic              xfer_irq,
    input  logic              pin_valid,
    input  logic [7:0]        pin_data,
    output logic              pin_ready,
    output logic              pout_valid,
    output logic [7:0]        pout_data,
    output logic              pout_par,
    input  logic              pout_ready,
    output logic              bus_req,
    input  logic              bus_gnt,
    output logic              bus_cyc,
    output logic              bus_we,
    output logic [ADDR_W-1:0] bus_addr,
    output logic [3:0]        bus_be,
    output logic [31:0]       bus_wdata,
    input  logic [31:0]       bus_rdata
);
    localparam int WORDS  = BURST_BYTES / 4;
    localparam int FILL_W = $clog2(BURST_BYTES + 1);
    localparam int BI_W   = $clog2(BURST_BYTES);
    localparam int WI_W   = $clog2(WORDS);
    localparam logic [FILL_W-1:0] FULL_LVL = FILL_W'(BURST_BYTES);

    eng_state_e        state_q;
    logic              dir_q, done_q, busy;
    logic [ADDR_W-1:0] addr_q;
    logic [CNT_W-1:0]  mem_left_q, chan_left_q;
    logic [FILL_W-1:0] fill_q, drain_q, wcnt_q, nwords_q, fetch_n;

    logic       stg_push, stg_pop, stg_full, stg_empty;
    logic [7:0] stg_din, stg_dout, buf_byte;
    logic [31:0] buf_word;
    logic       flush_now, in_pop, drain_go, last_word;
    word_cyc_t  wc;

    assign busy      = state_q != ST_IDLE;
    assign flush_now = dir_q && state_q == ST_FILL && fill_q != '0 &&
                       (fill_q == FULL_LVL || CNT_W'(fill_q) == mem_left_q);
    assign in_pop    = dir_q && state_q == ST_FILL && !stg_empty && !flush_now;
    assign drain_go  = !dir_q && state_q == ST_FILL && drain_q < fill_q && !stg_full;
    assign last_word = wcnt_q == nwords_q - 1'b1;
    assign fetch_n   = (mem_left_q >= CNT_W'(BURST_BYTES)) ? FULL_LVL
                                                           : FILL_W'(mem_left_q);

    // byte channel side
    assign pin_ready  = busy && dir_q && chan_left_q != '0 && !stg_full;
    assign stg_push   = dir_q ? (pin_valid && pin_ready) : drain_go;
    assign stg_din    = dir_q ? pin_data : buf_byte;
    assign stg_pop    = dir_q ? in_pop : (pout_valid && pout_ready);
    assign pout_valid = !dir_q && !stg_empty;
    assign pout_data  = stg_dout;
    assign pout_par   = odd_par(stg_dout);

    dma_stage_fifo #(.WIDTH(8), .DEPTH(STAGE_DEPTH)) stage_i (
        .clk(clk), .rst(rst),
        .push(stg_push), .din(stg_din),
        .pop(stg_pop), .dout(stg_dout),
        .full(stg_full), .empty(stg_empty)
    );

    dma_burst_buf #(.BYTES(BURST_BYTES)) buf_i (
        .clk(clk),
        .byte_we(in_pop), .byte_idx(fill_q[BI_W-1:0]), .byte_wd(stg_dout),
        .byte_rd_idx(drain_q[BI_W-1:0]), .byte_rd(buf_byte),
        .word_we(state_q == ST_BURST && !dir_q),
        .word_idx(wcnt_q[WI_W-1:0]), .word_wd(bus_rdata),
        .word_rd(buf_word)
    );

    // bus side
    always_comb begin
        wc.cyc  = state_q == ST_BURST;
        wc.we   = dir_q;
        wc.be   = lane_en(int'(wcnt_q) * 4, int'(fill_q));
        wc.data = dir_q ? buf_word : '0;
    end

    assign bus_req    = state_q == ST_REQ || state_q == ST_BURST;
    assign bus_cyc    = wc.cyc;
    assign bus_we     = wc.we;
    assign bus_be     = wc.be;
    assign bus_wdata  = wc.data;
    assign bus_addr   = addr_q;
    assign cfg_dir_rd = dir_q;
    assign xfer_done  = done_q;
    assign xfer_irq   = state_q == ST_FINISH;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q     <= ST_IDLE;
            dir_q       <= 1'b0;
            done_q      <= 1'b0;
            addr_q      <= '0;
            mem_left_q  <= '0;
            chan_left_q <= '0;
            fill_q      <= '0;
            drain_q     <= '0;
            wcnt_q      <= '0;
            nwords_q    <= '0;
        end else begin
            if (cfg_dir_we && !busy) dir_q <= cfg_dir_wd;
            if (pin_valid && pin_ready) chan_left_q <= chan_left_q - 1'b1;
            unique case (state_q)
                ST_IDLE: if (xfer_start) begin
                    done_q      <= 1'b0;
                    addr_q      <= xfer_addr & ~ADDR_W'(3);
                    mem_left_q  <= xfer_count;
                    chan_left_q <= dir_q ? xfer_count : '0;
                    fill_q      <= '0;
                    drain_q     <= '0;
                    state_q     <= (xfer_count == '0) ? ST_FINISH : ST_FILL;
                end
                ST_FILL: if (dir_q) begin
                    if (in_pop) fill_q <= fill_q + 1'b1;
                    if (flush_now) begin
                        nwords_q <= (fill_q + FILL_W'(3)) >> 2;
                        wcnt_q   <= '0;
                        state_q  <= ST_REQ;
                    end
                end else if (drain_go) begin
                    drain_q <= drain_q + 1'b1;
                end else if (drain_q == fill_q) begin
                    if (mem_left_q != '0) begin
                        fill_q   <= fetch_n;
                        drain_q  <= '0;
                        nwords_q <= (fetch_n + FILL_W'(3)) >> 2;
                        wcnt_q   <= '0;
                        state_q  <= ST_REQ;
                    end else if (stg_empty) begin
                        state_q <= ST_FINISH;
                    end
                end
                ST_REQ: if (bus_gnt) state_q <= ST_BURST;
                ST_BURST: begin
                    addr_q <= addr_q + ADDR_W'(4);
                    wcnt_q <= wcnt_q + 1'b1;
                    if (last_word) begin
                        mem_left_q <= mem_left_q - CNT_W'(fill_q);
                        if (dir_q) begin
                            fill_q  <= '0;
                            state_q <= (mem_left_q == CNT_W'(fill_q)) ? ST_FINISH
                                                                     : ST_FILL;
                        end else begin
                            state_q <= ST_FILL;
                        end
                    end
                end
                ST_FINISH: begin
                    done_q  <= 1'b1;
                    state_q <= ST_IDLE;
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/dma_burst_engine_chk.sv
module dma_burst_engine_chk #(
    parameter int ADDR_W = 32,
    parameter int WORDS  = 8
) (
    input logic              clk,
    input logic              rst,
    input logic              bus_req,
    input logic              bus_gnt,
    input logic              bus_cyc,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              pin_ready,
    input logic              pout_valid,
    input logic [7:0]        pout_data,
    input logic              pout_par,
    input logic              xfer_irq,
    input logic              xfer_done
);
    localparam int RW = $clog2(WORDS + 1) + 1;
    logic [RW-1:0] run_q;

    always_ff @(posedge clk) begin
        if (rst) run_q <= '0;
        else     run_q <= bus_cyc ? run_q + 1'b1 : '0;
    end

    a_r6_req_hold: assert property (@(posedge clk) disable iff (rst)
        (bus_req && !bus_cyc && !bus_gnt) |=> bus_req);

    a_r6_cyc_owned: assert property (@(posedge clk) disable iff (rst)
        bus_cyc |-> bus_req);

    a_r6_cyc_after_gnt: assert property (@(posedge clk) disable iff (rst)
        $rose(bus_cyc) |-> $past(bus_gnt));

    a_r7_addr_step: assert property (@(posedge clk) disable iff (rst)
        (bus_cyc && $past(bus_cyc)) |-> bus_addr == $past(bus_addr) + ADDR_W'(4));

    a_r2_burst_len: assert property (@(posedge clk) disable iff (rst)
        bus_cyc |-> run_q < RW'(WORDS));

    a_r5_odd_parity: assert property (@(posedge clk) disable iff (rst)
        pout_valid |-> (^{pout_data, pout_par}) == 1'b1);

    a_r9_irq_single: assert property (@(posedge clk) disable iff (rst)
        xfer_irq |=> (!xfer_irq && xfer_done));

    a_r4_one_direction: assert property (@(posedge clk) disable iff (rst)
        pin_ready |-> !pout_valid);
endmodule

bind dma_burst_engine dma_burst_engine_chk #(
    .ADDR_W(ADDR_W), .WORDS(BURST_BYTES / 4)
) chk_i (
    .clk(clk), .rst(rst),
    .bus_req(bus_req), .bus_gnt(bus_gnt), .bus_cyc(bus_cyc), .bus_addr(bus_addr),
    .pin_ready(pin_ready), .pout_valid(pout_valid), .pout_data(pout_data),
    .pout_par(pout_par), .xfer_irq(xfer_irq), .xfer_done(xfer_done)
);

// File: tb/dma_burst_engine_tb_top.sv
`timescale 1ns/1ps
module dma_burst_engine_tb_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cfg_dir_we = 1'b0, cfg_dir_wd = 1'b0, cfg_dir_rd;
    logic        xfer_start = 1'b0, xfer_done, xfer_irq;
    logic [31:0] xfer_addr = '0;
    logic [15:0] xfer_count = '0;
    logic        pin_valid, pin_ready, pout_valid, pout_par, pout_ready;
    logic [7:0]  pin_data, pout_data;
    logic        bus_req, bus_gnt, bus_cyc, bus_we;
    logic [31:0] bus_addr, bus_wdata, bus_rdata;
    logic [3:0]  bus_be;

    always #2 clk = ~clk;

    dma_burst_engine dut_i (
        .clk(clk), .rst(rst),
        .cfg_dir_we(cfg_dir_we), .cfg_dir_wd(cfg_dir_wd), .cfg_dir_rd(cfg_dir_rd),
        .xfer_start(xfer_start), .xfer_addr(xfer_addr), .xfer_count(xfer_count),
        .xfer_done(xfer_done), .xfer_irq(xfer_irq),
        .pin_valid(pin_valid), .pin_data(pin_data), .pin_ready(pin_ready),
        .pout_valid(pout_valid), .pout_data(pout_data), .pout_par(pout_par),
        .pout_ready(pout_ready),
        .bus_req(bus_req), .bus_gnt(bus_gnt), .bus_cyc(bus_cyc), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_be(bus_be), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata)
    );

    function automatic logic [7:0] pat(input logic [7:0] s, input int i);
        return (s + 8'(i * 29)) ^ 8'(i >> 2);
    endfunction

    // memory model: 64 words, reads answer within the word cycle
    logic [31:0] mem [64];
    assign bus_rdata = mem[bus_addr[7:2]];
    always @(posedge clk) begin
        if (bus_cyc && bus_we)
            for (int l = 0; l < 4; l++)
                if (bus_be[l]) mem[bus_addr[7:2]][8*l +: 8] <= bus_wdata[8*l +: 8];
    end
    function automatic logic [7:0] mbyte(input int a);
        return mem[a >> 2][8*(3 - (a & 3)) +: 8];
    endfunction

    // arbiter model: grant after gnt_lat cycles of request
    int gnt_lat = 0, wait_cnt = 0;
    always @(posedge clk) wait_cnt <= bus_req ? wait_cnt + 1 : 0;
    assign bus_gnt = bus_req && (wait_cnt >= gnt_lat);

    // peripheral source, sink and bus monitor
    logic       clr = 1'b0, sink_stall = 1'b0;
    logic [7:0] seed = '0;
    int src_n = 0, src_idx = 0, tick = 0;
    int snk_cnt = 0, par_err = 0;
    logic [7:0] snk_buf [256];
    int words_seen = 0, bursts_seen = 0, irq_seen = 0, step_err = 0, hold_err = 0;
    int first_addr = -1, req_rise_idx = -1, cyc_first_idx = -1;
    logic prev_cyc = 1'b0, prev_req = 1'b0;
    logic [31:0] prev_addr = '0;

    assign pin_valid  = src_idx < src_n;
    assign pin_data   = pat(seed, src_idx);
    assign pout_ready = !sink_stall || tick[0];

    always @(posedge clk) begin
        tick      <= tick + 1;
        prev_cyc  <= bus_cyc;
        prev_req  <= bus_req;
        prev_addr <= bus_addr;
        if (clr) begin
            src_idx <= 0; snk_cnt <= 0; par_err <= 0;
            words_seen <= 0; bursts_seen <= 0; irq_seen <= 0;
            step_err <= 0; hold_err <= 0;
            first_addr <= -1; req_rise_idx <= -1; cyc_first_idx <= -1;
        end else begin
            if (pin_valid && pin_ready) src_idx <= src_idx + 1;
            if (pout_valid && pout_ready) begin
                snk_buf[snk_cnt[7:0]] <= pout_data;
                snk_cnt <= snk_cnt + 1;
                if ((^{pout_data, pout_par}) != 1'b1) par_err <= par_err + 1;
            end
            if (bus_cyc) words_seen <= words_seen + 1;
            if (bus_cyc && !prev_cyc) begin
                bursts_seen <= bursts_seen + 1;
                if (first_addr < 0) begin
                    first_addr    <= int'(bus_addr);
                    cyc_first_idx <= src_idx;
                end
            end
            if (bus_cyc && prev_cyc && bus_addr != prev_addr + 32'd4)
                step_err <= step_err + 1;
            if (bus_req && !bus_cyc && prev_cyc) hold_err <= hold_err + 1;
            if (bus_req && !prev_req && req_rise_idx < 0) req_rise_idx <= src_idx;
            if (xfer_irq) irq_seen <= irq_seen + 1;
        end
    end

    int n_checks = 0, n_fail = 0;
    bit finished = 0;

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic set_dir(input logic v);
        @(negedge clk); cfg_dir_we = 1'b1; cfg_dir_wd = v;
        @(negedge clk); cfg_dir_we = 1'b0;
    endtask

    task automatic clear_mon();
        @(negedge clk); clr = 1'b1;
        @(negedge clk); clr = 1'b0;
    endtask

    task automatic start(input int a, input int n);
        @(negedge clk); xfer_start = 1'b1; xfer_addr = 32'(a); xfer_count = 16'(n);
        @(negedge clk); xfer_start = 1'b0;
    endtask

    task automatic wait_done(input string tag);
        int k;
        for (k = 0; k < 4000; k++) begin
            if (xfer_done) break;
            @(negedge clk);
        end
        check(xfer_done == 1'b1, tag, int'(xfer_done), 1);
    endtask

    function automatic int exp_words(input int n);
        int w = 0, rem = n;
        while (rem > 0) begin
            int c = (rem > 32) ? 32 : rem;
            w += (c + 3) / 4;
            rem -= c;
        end
        return w;
    endfunction

    typedef struct packed {
        logic       dir;
        logic [7:0] addr;
        logic [15:0] cnt;
        logic [7:0] lat;
        logic [7:0] sd;
        logic       stall;
    } vec_t;

    localparam vec_t VECS [6] = '{
        '{1'b1, 8'h00, 16'd32, 8'd0,  8'h11, 1'b0},
        '{1'b1, 8'h80, 16'd70, 8'd40, 8'h22, 1'b0},
        '{1'b1, 8'h23, 16'd5,  8'd3,  8'h5c, 1'b0},
        '{1'b0, 8'h40, 16'd32, 8'd0,  8'h33, 1'b0},
        '{1'b0, 8'h10, 16'd45, 8'd5,  8'h44, 1'b1},
        '{1'b0, 8'hc4, 16'd3,  8'd2,  8'h55, 1'b1}
    };

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_checks++; n_fail++;
            $display("FAIL watchdog: actual 1 expected 0");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 / R9 reset state
        check(cfg_dir_rd == 1'b0, "R1 reset dir", int'(cfg_dir_rd), 0);
        check(!bus_req && !xfer_done && !xfer_irq, "R9 reset idle",
              int'({bus_req, xfer_done, xfer_irq}), 0);
        check(!pin_ready && !pout_valid, "R4 reset channel",
              int'({pin_ready, pout_valid}), 0);

        foreach (VECS[v]) begin
            vec_t t = VECS[v];
            int base = int'(t.addr) & ~3;
            int n = int'(t.cnt);
            int bad = 0;
            for (int w = 0; w < 64; w++)
                mem[w] = t.dir ? 32'ha5a5a5a5
                               : {pat(t.sd, 4*w), pat(t.sd, 4*w+1),
                                  pat(t.sd, 4*w+2), pat(t.sd, 4*w+3)};
            gnt_lat = int'(t.lat);
            sink_stall = t.stall;
            seed = t.sd;
            src_n = 0;
            set_dir(t.dir);
            check(cfg_dir_rd == t.dir, "R1 dir readback", int'(cfg_dir_rd), int'(t.dir));
            clear_mon();
            src_n = t.dir ? n : 0;
            start(int'(t.addr), n);
            wait_done("R9 done set");
            @(negedge clk);
            check(irq_seen == 1, "R9 irq single pulse", irq_seen, 1);
            check(bursts_seen == (n + 31) / 32, "R2 R4 burst count",
                  bursts_seen, (n + 31) / 32);
            check(words_seen == exp_words(n), "R8 word cycles", words_seen, exp_words(n));
            check(first_addr == base && step_err == 0, "R7 address sequence",
                  first_addr, base);
            check(hold_err == 0 && !bus_req, "R6 release after burst", hold_err, 0);
            if (t.dir) begin
                for (int i = 0; i < n; i++)
                    if (mbyte(base + i) != pat(t.sd, i)) bad++;
                check(bad == 0, "R3 packed bytes in memory", bad, 0);
                check(mbyte(base + n) == 8'ha5, "R8 lanes past end untouched",
                      int'(mbyte(base + n)), 'ha5);
                check(req_rise_idx >= ((n < 32) ? n : 32), "R2 request only when ready",
                      req_rise_idx, (n < 32) ? n : 32);
                if (t.lat >= 8'd40)
                    check(cyc_first_idx == 40, "R11 staging absorbs 8 more",
                          cyc_first_idx, 40);
            end else begin
                for (int i = 0; i < n; i++)
                    if (snk_buf[i] != pat(t.sd, base + i)) bad++;
                check(bad == 0 && snk_cnt == n, "R4 R3 bytes to peripheral", snk_cnt, n);
                check(par_err == 0, "R5 odd parity", par_err, 0);
            end
        end

        // zero count: finishes without touching the bus
        set_dir(1'b1);
        src_n = 0;
        clear_mon();
        start(0, 0);
        wait_done("R9 zero count done");
        @(negedge clk);
        check(irq_seen == 1 && words_seen == 0 && req_rise_idx < 0,
              "R9 zero count no bus", words_seen, 0);

        // busy: direction write and second start are ignored
        set_dir(1'b0);
        gnt_lat = 30;
        sink_stall = 1'b0;
        seed = 8'h66;
        for (int w = 0; w < 64; w++)
            mem[w] = {pat(8'h66, 4*w), pat(8'h66, 4*w+1), pat(8'h66, 4*w+2), pat(8'h66, 4*w+3)};
        clear_mon();
        start(8, 8);
        repeat (5) @(negedge clk);
        cfg_dir_we = 1'b1; cfg_dir_wd = 1'b1;
        @(negedge clk);
        cfg_dir_we = 1'b0;
        start(0, 100);
        wait_done("R10 busy transfer done");
        @(negedge clk);
        check(cfg_dir_rd == 1'b0, "R1 write ignored while busy", int'(cfg_dir_rd), 0);
        check(snk_cnt == 8 && words_seen == 2, "R10 start ignored while busy", snk_cnt, 8);
        check(!pin_ready, "R4 no input when dir 0", int'(pin_ready), 0);

        finished = 1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule